// File: doc/BRIEF.md
# SCL Phase Generator

This block times the clock line of an I2C master. A byte engine asks it for one bus event at a time (a START, a STOP, a single data bit or an idle gap), and it drives SCL and SDA through that event. It signals when SDA was changed and when it was sampled, and it pulses a completion strobe at the end. Four counts, all in system clock cycles, set the timing: the full bit period, the low part of that period, the hold and setup time around START and STOP, and the data setup time before SCL rises.

Each drive output is open-drain style: 1 releases the line and 0 pulls it low. SCL and SDA readback pass through a two-stage synchronizer. The high phase of a bit does not begin counting until the synchronized SCL readback shows high, so a target that holds SCL low stretches the bit. A manual mode turns off the sequencer and hands SCL to a software-controlled level, for bus recovery. A four-bit monitor shows the driven and sensed levels of both lines.

Top module: `scl_phase_gen`

## Requirements
- R1: After synchronous reset `scl_drv` and `sda_drv` are 1 and `op_done` is 0. With a valid configuration and `run_mode` high, `req_ready` is 1 within two cycles.
- R2: A bit request is `req_cmd` = 3. SCL is released exactly `cfg_low` cycles after the request is accepted.
- R3: In a bit, `sda_chg` pulses and SDA takes `req_bit` a number of cycles before SCL is released. That number is `cfg_dsetup` clamped to the range 1 to `cfg_low`. SDA changes only while SCL is driven low.
- R4: If SCL is not stretched, it stays released for `cfg_period - cfg_low` cycles when that difference is above 3, and for 4 cycles otherwise. After that it is pulled low and `op_done` pulses.
- R5: Each cycle that the SCL readback stays low after SCL is released lengthens the high phase by one cycle.
- R6: `sda_smp` pulses only while SCL is released. After the bit, `rx_bit` holds the SDA readback seen when SCL rose.
- R7: A START (`req_cmd` = 1) on an idle bus pulls SDA low at once. It pulls SCL low `cfg_hold` cycles later, with `op_done`.
- R8: A START while SCL is low is a repeated START. SDA is released at once and SCL is released `cfg_dsetup` cycles later. SDA falls `cfg_hold + 3` cycles after SCL is released, and SCL falls `cfg_hold` cycles after that.
- R9: A STOP (`req_cmd` = 2) pulls SDA low at once and releases SCL `cfg_dsetup` cycles later. It releases SDA with `op_done` `cfg_hold + 3` cycles after SCL is released.
- R10: An idle request (`req_cmd` = 0) leaves both lines unchanged and pulses `op_done` for one cycle, `cfg_period` cycles after acceptance.
- R11: If `cfg_period` or `cfg_low` is zero, or `cfg_low` is not below `cfg_period`, both lines are released, `req_ready` is 0 and no `op_done` occurs.
- R12: With `run_mode` low, `scl_drv` follows `man_scl_rel` one cycle later, SDA is released, and `req_ready` and `op_done` stay 0.
- R13: `bus_mon` bit 0 is the synchronized SCL readback, bit 1 is `scl_drv`, bit 2 is the synchronized SDA readback and bit 3 is `sda_drv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_mode | input | 1 | 1 = sequencer runs, 0 = manual SCL control |
| man_scl_rel | input | 1 | Manual SCL level: 1 release, 0 pull low |
| cfg_period | input | CW | Full bit period in cycles |
| cfg_low | input | CW | SCL low time in cycles |
| cfg_hold | input | CW | START hold and START/STOP setup time |
| cfg_dsetup | input | CW | SDA change to SCL rise delay |
| req_valid | input | 1 | Request present |
| req_cmd | input | 2 | 0 idle, 1 START, 2 STOP, 3 bit |
| req_bit | input | 1 | SDA value for a bit request |
| req_ready | output | 1 | Request is accepted on this edge if valid |
| op_done | output | 1 | One-cycle completion pulse |
| scl_in | input | 1 | SCL line readback |
| sda_in | input | 1 | SDA line readback |
| scl_drv | output | 1 | SCL drive, 1 release |
| sda_drv | output | 1 | SDA drive, 1 release |
| sda_chg | output | 1 | Pulse: SDA drive updated during SCL low |
| sda_smp | output | 1 | Pulse: SDA sampled at SCL rise |
| rx_bit | output | 1 | Last sampled SDA value |
| bus_mon | output | 4 | Drive and readback levels of both lines |

## Verification
A corrupted phase counter or state register shows at the ports within one bit time. Such a fault shifts the cycle in which `scl_drv` rises or falls, `sda_chg` fires or `op_done` arrives, and each of those is measured against the count that the configuration predicts. A wrong clamp or a high count without compensation changes the low or high length by at least one cycle in the bit that follows. A stuck wait on the readback leaves `op_done` missing, and the bench reports that as a miss of the expected edge. Faults in the forcing paths for manual mode and invalid configuration show as a toggle or a strobe on a line that should stay still, within a few cycles.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_START = 2'd1,
    CMD_STOP  = 2'd2,
    CMD_BIT   = 2'd3
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SHOLD, ST_RLOW, ST_RWAIT, ST_RSETUP,
    ST_BLOW1, ST_BLOW2, ST_BWAIT, ST_BHIGH,
    ST_PLOW, ST_PWAIT, ST_PSETUP, ST_IWAIT
  } phase_e;
endpackage

// File: rtl/scl_phase_sync.sv
module scl_phase_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '1;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= '1;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/scl_phase_cfg.sv
module scl_phase_cfg #(
  parameter int CW  = 16,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] low,
  input  logic [CW-1:0] hold,
  input  logic [CW-1:0] dsetup,
  output logic          cfg_ok,
  output logic          lead_zero,
  output logic [CW-1:0] lead_m1,
  output logic [CW-1:0] ds_m1,
  output logic [CW-1:0] hi_m1,
  output logic [CW-1:0] hold_m1,
  output logic [CW-1:0] per_m1
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] LATV = CW'(LAT);

  logic          ok_c;
  logic [CW-1:0] ds_c, hi_c;

  always_comb begin
    ok_c = (period != '0) && (low != '0) && (low < period);
    if (dsetup == '0)     ds_c = ONE;
    else if (dsetup > low) ds_c = low;
    else                   ds_c = dsetup;
    hi_c = period - low;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_ok    <= 1'b0;
      lead_zero <= 1'b1;
      lead_m1   <= '0;
      ds_m1     <= '0;
      hi_m1     <= '0;
      hold_m1   <= '0;
      per_m1    <= '0;
    end else begin
      cfg_ok    <= ok_c;
      lead_zero <= (low == ds_c);
      lead_m1   <= low - ds_c - ONE;
      ds_m1     <= ds_c - ONE;
      hi_m1     <= (hi_c > LATV) ? hi_c - LATV - ONE : '0;
      hold_m1   <= (hold == '0) ? '0 : hold - ONE;
      per_m1    <= period - ONE;
    end
  end
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_mode,
  input  logic          man_scl_rel,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_low,
  input  logic [CW-1:0] cfg_hold,
  input  logic [CW-1:0] cfg_dsetup,
  input  logic          req_valid,
  input  logic [1:0]    req_cmd,
  input  logic          req_bit,
  output logic          req_ready,
  output logic          op_done,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_drv,
  output logic          sda_drv,
  output logic          sda_chg,
  output logic          sda_smp,
  output logic          rx_bit,
  output logic [3:0]    bus_mon
);
  import scl_phase_pkg::*;

  localparam int LAT = SYNC_STAGES + 1;

  logic          scl_s, sda_s;
  logic          cfg_ok, lead_zero, cnt_zero;
  logic [CW-1:0] lead_m1, ds_m1, hi_m1, hold_m1, per_m1;

  phase_e        st, st_n;
  logic          scl_q, sda_q, done_q, chg_q, smp_q, rx_q, bit_q;
  logic          scl_n, sda_n, done_n, chg_n, smp_n, rx_n, bit_n;
  logic          ld;
  logic [CW-1:0] ld_val;

  scl_phase_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({sda_in, scl_in}), .q({sda_s, scl_s})
  );

  scl_phase_cfg #(.CW(CW), .LAT(LAT)) u_cfg (
    .clk(clk), .rst(rst),
    .period(cfg_period), .low(cfg_low), .hold(cfg_hold), .dsetup(cfg_dsetup),
    .cfg_ok(cfg_ok), .lead_zero(lead_zero), .lead_m1(lead_m1),
    .ds_m1(ds_m1), .hi_m1(hi_m1), .hold_m1(hold_m1), .per_m1(per_m1)
  );

  scl_phase_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .zero(cnt_zero)
  );

  always_comb begin
    st_n   = st;
    ld     = 1'b0;
    ld_val = '0;
    scl_n  = scl_q;
    sda_n  = sda_q;
    done_n = 1'b0;
    chg_n  = 1'b0;
    smp_n  = 1'b0;
    rx_n   = rx_q;
    bit_n  = bit_q;
    if (!run_mode) begin
      st_n  = ST_IDLE;
      scl_n = man_scl_rel;
      sda_n = 1'b1;
    end else if (!cfg_ok) begin
      st_n  = ST_IDLE;
      scl_n = 1'b1;
      sda_n = 1'b1;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          case (cmd_e'(req_cmd))
            CMD_START: begin
              ld = 1'b1;
              if (scl_q) begin
                sda_n = 1'b0; st_n = ST_SHOLD; ld_val = hold_m1;
              end else begin
                sda_n = 1'b1; chg_n = 1'b1; st_n = ST_RLOW; ld_val = ds_m1;
              end
            end
            CMD_STOP: begin
              scl_n = 1'b0; sda_n = 1'b0; chg_n = 1'b1;
              st_n = ST_PLOW; ld = 1'b1; ld_val = ds_m1;
            end
            CMD_BIT: begin
              scl_n = 1'b0; bit_n = req_bit; ld = 1'b1;
              if (lead_zero) begin
                sda_n = req_bit; chg_n = 1'b1; st_n = ST_BLOW2; ld_val = ds_m1;
              end else begin
                st_n = ST_BLOW1; ld_val = lead_m1;
              end
            end
            default: begin
              st_n = ST_IWAIT; ld = 1'b1; ld_val = per_m1;
            end
          endcase
        end
        ST_SHOLD:  if (cnt_zero) begin scl_n = 1'b0; done_n = 1'b1; st_n = ST_IDLE; end
        ST_RLOW:   if (cnt_zero) begin scl_n = 1'b1; st_n = ST_RWAIT; end
        ST_RWAIT:  if (scl_s) begin st_n = ST_RSETUP; ld = 1'b1; ld_val = hold_m1; end
        ST_RSETUP: if (cnt_zero) begin
          sda_n = 1'b0; st_n = ST_SHOLD; ld = 1'b1; ld_val = hold_m1;
        end
        ST_BLOW1:  if (cnt_zero) begin
          sda_n = bit_q; chg_n = 1'b1; st_n = ST_BLOW2; ld = 1'b1; ld_val = ds_m1;
        end
        ST_BLOW2:  if (cnt_zero) begin scl_n = 1'b1; st_n = ST_BWAIT; end
        ST_BWAIT:  if (scl_s) begin
          smp_n = 1'b1; rx_n = sda_s; st_n = ST_BHIGH; ld = 1'b1; ld_val = hi_m1;
        end
        ST_BHIGH:  if (cnt_zero) begin scl_n = 1'b0; done_n = 1'b1; st_n = ST_IDLE; end
        ST_PLOW:   if (cnt_zero) begin scl_n = 1'b1; st_n = ST_PWAIT; end
        ST_PWAIT:  if (scl_s) begin st_n = ST_PSETUP; ld = 1'b1; ld_val = hold_m1; end
        ST_PSETUP: if (cnt_zero) begin sda_n = 1'b1; done_n = 1'b1; st_n = ST_IDLE; end
        ST_IWAIT:  if (cnt_zero) begin done_n = 1'b1; st_n = ST_IDLE; end
        default:   st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      done_q <= 1'b0;
      chg_q  <= 1'b0;
      smp_q  <= 1'b0;
      rx_q   <= 1'b1;
      bit_q  <= 1'b1;
    end else begin
      st     <= st_n;
      scl_q  <= scl_n;
      sda_q  <= sda_n;
      done_q <= done_n;
      chg_q  <= chg_n;
      smp_q  <= smp_n;
      rx_q   <= rx_n;
      bit_q  <= bit_n;
    end
  end

  assign req_ready = run_mode && cfg_ok && (st == ST_IDLE);
  assign op_done   = done_q;
  assign scl_drv   = scl_q;
  assign sda_drv   = sda_q;
  assign sda_chg   = chg_q;
  assign sda_smp   = smp_q;
  assign rx_bit    = rx_q;
  assign bus_mon   = {sda_q, sda_s, scl_q, scl_s};

  // SDA is only moved by the sequencer while SCL is held low.
  p_chg_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
    chg_q |-> !scl_q);

  // SDA must have settled before SCL is released in normal operation.
  p_rise_sda_settled_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(scl_q) && $past(run_mode) && $past(cfg_ok)) |-> $stable(sda_q));

  p_sample_scl_high_r6: assert property (@(posedge clk) disable iff (rst)
    smp_q |-> scl_q);

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  p_bad_cfg_release_r11: assert property (@(posedge clk) disable iff (rst)
    (run_mode && !cfg_ok) |=> (scl_q && sda_q && !done_q));

  p_manual_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !run_mode |=> (sda_q && !done_q && !chg_q));
endmodule

// File: tb/scl_phase_gen_bench.sv
module scl_phase_gen_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_mode = 1'b1;
  logic          man_scl_rel = 1'b1;
  logic [CW-1:0] cfg_period = 16'd40;
  logic [CW-1:0] cfg_low = 16'd22;
  logic [CW-1:0] cfg_hold = 16'd10;
  logic [CW-1:0] cfg_dsetup = 16'd5;
  logic          req_valid = 1'b0;
  logic [1:0]    req_cmd = 2'd0;
  logic          req_bit = 1'b0;
  logic          req_ready, op_done, scl_drv, sda_drv, sda_chg, sda_smp, rx_bit;
  logic [3:0]    bus_mon;
  logic          stretch = 1'b0;
  logic          slave_sda = 1'b1;
  logic          scl_in, sda_in;

  int vectors = 0;
  int miscompares = 0;

  int i_rise, i_sfall, i_sdrise, i_sdfall, i_chg, i_smp, i_done;

  always #10 clk = ~clk;

  assign scl_in = scl_drv & ~stretch;
  assign sda_in = sda_drv & slave_sda;

  scl_phase_gen #(.CW(CW)) u_scl_phase_gen (
    .clk(clk), .rst(rst), .run_mode(run_mode), .man_scl_rel(man_scl_rel),
    .cfg_period(cfg_period), .cfg_low(cfg_low), .cfg_hold(cfg_hold),
    .cfg_dsetup(cfg_dsetup), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bit(req_bit), .req_ready(req_ready), .op_done(op_done),
    .scl_in(scl_in), .sda_in(sda_in), .scl_drv(scl_drv), .sda_drv(sda_drv),
    .sda_chg(sda_chg), .sda_smp(sda_smp), .rx_bit(rx_bit), .bus_mon(bus_mon)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int p, input int l, input int h, input int d);
    @(negedge clk);
    cfg_period = CW'(p); cfg_low = CW'(l); cfg_hold = CW'(h); cfg_dsetup = CW'(d);
    repeat (3) @(negedge clk);
  endtask

  // Issues one request and records the sample index of each event,
  // counting negedges after the accepting edge from 0.
  task automatic run_op(input logic [1:0] cmd, input logic b, input int d);
    logic ps, pd;
    for (int w = 0; w < 50 && !req_ready; w++) @(negedge clk);
    ps = scl_drv; pd = sda_drv;
    req_valid = 1'b1; req_cmd = cmd; req_bit = b;
    if (d > 0) stretch = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    i_rise = -1; i_sfall = -1; i_sdrise = -1; i_sdfall = -1;
    i_chg = -1; i_smp = -1; i_done = -1;
    for (int k = 0; k < 2000; k++) begin
      if (scl_drv && !ps && i_rise < 0) i_rise = k;
      if (!scl_drv && ps && i_sfall < 0) i_sfall = k;
      if (sda_drv && !pd && i_sdrise < 0) i_sdrise = k;
      if (!sda_drv && pd && i_sdfall < 0) i_sdfall = k;
      if (sda_chg && i_chg < 0) i_chg = k;
      if (sda_smp && i_smp < 0) i_smp = k;
      if (i_rise >= 0 && k == i_rise + d) stretch = 1'b0;
      ps = scl_drv; pd = sda_drv;
      if (op_done) begin i_done = k; break; end
      @(negedge clk);
    end
    stretch = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 scl_drv after reset", int'(scl_drv), 1);
    chk("R1 sda_drv after reset", int'(sda_drv), 1);
    chk("R1 op_done after reset", int'(op_done), 0);
    repeat (2) @(negedge clk);
    chk("R1 req_ready", int'(req_ready), 1);
  endtask

  task automatic t_start_idle;
    run_op(2'd1, 1'b0, 0);
    chk("R7 SDA falls at once", i_sdfall, 0);
    chk("R7 SCL falls after hold", i_sfall, 10);
    chk("R7 done after hold", i_done, 10);
  endtask

  task automatic t_bit_basic;
    slave_sda = 1'b1;
    run_op(2'd3, 1'b1, 0);
    chk("R2 SCL rise after low", i_rise, 22);
    chk("R3 SDA change before rise", i_chg, 17);
    chk("R3 SDA drive updated", i_sdrise, 17);
    chk("R4 high length", i_done - i_rise, 18);
    chk("R6 sample point", i_smp, 25);
    chk("R6 rx released", int'(rx_bit), 1);
    slave_sda = 1'b0;
    run_op(2'd3, 1'b1, 0);
    chk("R6 rx pulled by target", int'(rx_bit), 0);
    slave_sda = 1'b1;
  endtask

  task automatic t_stretch;
    run_op(2'd3, 1'b1, 5);
    chk("R5 stretched high length", i_done - i_rise, 23);
    chk("R5 rise unaffected", i_rise, 22);
  endtask

  task automatic t_clamp;
    set_cfg(40, 22, 10, 0);
    run_op(2'd3, 1'b0, 0);
    chk("R3 zero setup clamps to 1", i_rise - i_chg, 1);
    set_cfg(40, 22, 10, 100);
    run_op(2'd3, 1'b1, 0);
    chk("R3 large setup clamps to low", i_chg, 0);
    chk("R2 rise with clamped setup", i_rise, 22);
    set_cfg(40, 22, 10, 5);
  endtask

  task automatic t_short_high;
    set_cfg(24, 22, 10, 5);
    run_op(2'd3, 1'b1, 0);
    chk("R4 minimum high length", i_done - i_rise, 4);
    set_cfg(40, 22, 10, 5);
  endtask

  task automatic t_restart;
    run_op(2'd3, 1'b0, 0);
    run_op(2'd1, 1'b0, 0);
    chk("R8 SDA released at once", i_sdrise, 0);
    chk("R8 SCL released after setup", i_rise, 5);
    chk("R8 SDA falls after hold", i_sdfall, 18);
    chk("R8 SCL falls after hold", i_sfall, 28);
    chk("R8 done", i_done, 28);
  endtask

  task automatic t_stop;
    run_op(2'd3, 1'b1, 0);
    run_op(2'd2, 1'b0, 0);
    chk("R9 SDA low at once", i_sdfall, 0);
    chk("R9 SCL released", i_rise, 5);
    chk("R9 SDA released", i_sdrise, 18);
    chk("R9 done with SDA release", i_done, 18);
    chk("R9 SCL stays released", int'(scl_drv), 1);
  endtask

  task automatic t_idle_req;
    run_op(2'd0, 1'b0, 0);
    chk("R10 done after period", i_done, 40);
    chk("R10 SCL unchanged", i_rise + i_sfall, -2);
    chk("R10 SDA unchanged", i_sdrise + i_sdfall, -2);
    @(negedge clk);
    chk("R10 done single cycle", int'(op_done), 0);
  endtask

  task automatic t_bad_one(input int p, input int l);
    int dn, lo;
    set_cfg(p, l, 10, 5);
    chk("R11 ready low", int'(req_ready), 0);
    dn = 0; lo = 0;
    req_valid = 1'b1; req_cmd = 2'd3;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (op_done) dn++;
      if (!scl_drv || !sda_drv) lo++;
    end
    req_valid = 1'b0;
    chk("R11 no done", dn, 0);
    chk("R11 lines released", lo, 0);
  endtask

  task automatic t_bad_cfg;
    t_bad_one(0, 22);
    t_bad_one(40, 0);
    t_bad_one(30, 30);
    set_cfg(40, 22, 10, 5);
  endtask

  task automatic t_manual;
    @(negedge clk);
    run_mode = 1'b0; man_scl_rel = 1'b0; slave_sda = 1'b0;
    @(negedge clk);
    chk("R12 SCL follows manual low", int'(scl_drv), 0);
    chk("R12 SDA released", int'(sda_drv), 1);
    chk("R12 ready low", int'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk("R13 monitor SCL low SDA pulled", int'(bus_mon), 8);
    man_scl_rel = 1'b1; stretch = 1'b1; slave_sda = 1'b1;
    @(negedge clk);
    chk("R12 SCL follows manual release", int'(scl_drv), 1);
    repeat (3) @(negedge clk);
    chk("R13 monitor SCL held externally", int'(bus_mon), 14);
    stretch = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13 monitor all high", int'(bus_mon), 15);
    run_mode = 1'b1;
    @(negedge clk);
    chk("R12 ready back in normal mode", int'(req_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_start_idle();
    t_bit_basic();
    t_stretch();
    t_clamp();
    t_short_high();
    t_restart();
    t_stop();
    t_idle_req();
    t_bad_cfg();
    t_manual();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule